// File: doc/BRIEF.md
# Serial Audio Word Transmitter

This block turns parallel audio samples into a serial bit stream for a codec or amplifier. A producer writes one sample at a time into a single-entry holding register with a valid/ready handshake. The transmitter copies that register into a shift register at the start of each slot and sends it most significant bit first, one bit per bit-clock launch edge. A frame holds one or more contiguous words, for example left then right. Another agent generates the bit clock and the frame sync and presents them here as single-cycle edge strobes in the system clock domain.

The sample length is selected by a 3-bit code. The first bit follows the sampled frame sync after either zero or one bit period. A control bit selects which bit-clock edge launches data. Another control bit decides whether a frame sync that arrives while a frame is still in progress restarts the frame or is ignored. A transmitter reset input holds the shifter idle. Once it is released, nothing is sent until a frame sync is seen. If no fresh sample is waiting when a slot begins, the previous sample is sent again and a sticky underrun flag is raised.

Top module: `audio_word_tx`

## Requirements
- R1: The length code selects the word length. Codes 0 to 5 give 8, 12, 16, 20, 24 and 32 bits, and codes 6 and 7 also give 32 bits. A word of L bits is taken from wordData[L-1:0] and sent bit L-1 first, one bit per launch edge.
- R2: frameLen holds the number of words per frame minus one. The words of a frame follow each other with no gap. After the last bit of the frame, sdata goes low on the next launch edge unless a new frame starts there.
- R3: With dataDelay=0, the first bit appears on the launch edge where fsync is sampled high. With dataDelay=1, it appears one launch edge later. With dataDelay=1, a sync sampled on the edge that launches the final bit of a frame starts the next frame with no idle bit.
- R4: With ignoreSync=1, a sync sampled while a frame is in progress has no effect. With ignoreSync=0, such a sync abandons the current word and restarts the frame at word 0, applying the data delay.
- R5: While txRst is high, sdata is low and the underrun flag is cleared. After txRst is released, no word is loaded and sdata stays low until a sync is sampled on a launch edge. The holding register keeps its content through txRst.
- R6: With clkPol=1, bclkFall is the launch edge. With clkPol=0, bclkRise is the launch edge. fsync is sampled only on launch edges. sdata changes only in the clock cycle after a launch strobe, or after txRst.
- R7: wordReady is high while the holding register is empty, and a word is accepted when wordValid and wordReady are both high. wordTaken pulses for one cycle, one cycle after the held word is copied into the shifter, once per word.
- R8: If the holding register is empty when a slot starts, the previous word is sent again, underrun is set and stays set, and wordTaken does not pulse.
- R9: After rstN, sdata is 0, wordReady is 1, wordTaken is 0 and underrun is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| txRst | input | 1 | Transmitter hold; high keeps the shifter idle |
| clkPol | input | 1 | 1: falling bit-clock edge launches data; 0: rising edge |
| bclkRise | input | 1 | One-cycle strobe marking a rising bit-clock edge |
| bclkFall | input | 1 | One-cycle strobe marking a falling bit-clock edge |
| fsync | input | 1 | Frame sync, active high, sampled on launch edges |
| wordLenCode | input | 3 | Word length code |
| frameLen | input | 2 | Words per frame minus one |
| dataDelay | input | 1 | Bit periods between the sync and the first bit (0 or 1) |
| ignoreSync | input | 1 | 1: ignore syncs sampled during a frame |
| wordData | input | 32 | Sample to transmit, right-aligned |
| wordValid | input | 1 | Producer offers wordData |
| wordReady | output | 1 | Holding register empty |
| wordTaken | output | 1 | Pulse: held word moved into the shifter |
| sdata | output | 1 | Serial data |
| underrun | output | 1 | Sticky: a slot started with no fresh word |

## Verification
The bench checks the boundary between frames with a one-bit delay. Here the next sync falls on the final bit. A design that treated that sync as a mid-frame restart would cut off the last bit, and one that inserted an idle bit would shift the whole next frame by one. The bench sends a sync halfway through a word in both ignore settings. This catches a design that ignores the control and either restarts or continues regardless. It sends a sync on the non-launch edge, which a design sampling both edges would wrongly accept. It lets a slot start with nothing fresh queued, so a design that sent zeros, stalled or pulsed wordTaken on the repeated word gives a wrong bit stream or a wrong pulse count. Every length code is swept, which exposes an off-by-one in the bit count or a wrongly aligned MSB.

// File: rtl/atx_pkg.sv
package atx_pkg;

  typedef enum logic [1:0] {
    ST_ARM   = 2'd0,
    ST_GAP   = 2'd1,
    ST_SHIFT = 2'd2
  } txState_t;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic clear;     // transmitter held in reset
    logic loadWord;  // start a slot: copy held or previous word
    logic shiftBit;  // launch the next bit of the current word
    logic idleLine;  // drive the line low
  } txStrobe_t;

  // word length in bits for a length code, limited to the datapath width
  function automatic int unsigned wordBits(input logic [2:0] code,
                                           input int unsigned maxBits);
    int unsigned b;
    case (code)
      3'd0:    b = 8;
      3'd1:    b = 12;
      3'd2:    b = 16;
      3'd3:    b = 20;
      3'd4:    b = 24;
      default: b = 32;
    endcase
    return (b > maxBits) ? maxBits : b;
  endfunction

endpackage

// File: rtl/atx_ctrl.sv
module atx_ctrl
  import atx_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int FRAME_W = 2,
  localparam int CNT_W  = $clog2(DATA_W)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               txRst,
  input  logic               launch,
  input  logic               fsync,
  input  logic [2:0]         wordLenCode,
  input  logic [FRAME_W-1:0] frameLen,
  input  logic               dataDelay,
  input  logic               ignoreSync,
  output txStrobe_t          strobe
);

  txState_t           state, nxtState;
  logic [CNT_W-1:0]   remain, nxtRemain;
  logic [FRAME_W-1:0] slot, nxtSlot;
  logic [CNT_W-1:0]   lenM1;
  logic               lastSlot;
  logic               startFrame;
  logic               nextWord;

  assign lenM1    = CNT_W'(wordBits(wordLenCode, DATA_W) - 1);
  assign lastSlot = (slot >= frameLen);

  always_comb begin
    nxtState   = state;
    nxtRemain  = remain;
    nxtSlot    = slot;
    strobe     = '0;
    startFrame = 1'b0;
    nextWord   = 1'b0;
    if (txRst) begin
      strobe.clear = 1'b1;
      nxtState     = ST_ARM;
      nxtRemain    = '0;
      nxtSlot      = '0;
    end else if (launch) begin
      case (state)
        ST_ARM: begin
          if (fsync) startFrame = 1'b1;
          else       strobe.idleLine = 1'b1;
        end
        ST_GAP: begin
          if (fsync && !ignoreSync) startFrame = 1'b1;
          else                      nextWord   = 1'b1;
        end
        ST_SHIFT: begin
          if (remain != '0) begin
            if (fsync && dataDelay && lastSlot && remain == CNT_W'(1)) begin
              // expected sync on the final bit: next frame after one bit
              strobe.shiftBit = 1'b1;
              nxtSlot         = '0;
              nxtState        = ST_GAP;
            end else if (fsync && !ignoreSync) begin
              startFrame = 1'b1;
            end else begin
              strobe.shiftBit = 1'b1;
              nxtRemain       = remain - CNT_W'(1);
            end
          end else if (!lastSlot) begin
            if (fsync && !ignoreSync) begin
              startFrame = 1'b1;
            end else begin
              nextWord = 1'b1;
              nxtSlot  = slot + FRAME_W'(1);
            end
          end else begin
            if (fsync) begin
              startFrame = 1'b1;
            end else begin
              strobe.idleLine = 1'b1;
              nxtState        = ST_ARM;
            end
          end
        end
        default: begin
          strobe.idleLine = 1'b1;
          nxtState        = ST_ARM;
        end
      endcase
      if (startFrame) begin
        nxtSlot = '0;
        if (dataDelay) begin
          strobe.idleLine = 1'b1;
          nxtState        = ST_GAP;
        end else begin
          nextWord = 1'b1;
        end
      end
      if (nextWord) begin
        strobe.loadWord = 1'b1;
        nxtRemain       = lenM1;
        nxtState        = ST_SHIFT;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_ARM;
      remain <= '0;
      slot   <= '0;
    end else begin
      state  <= nxtState;
      remain <= nxtRemain;
      slot   <= nxtSlot;
    end
  end

  // R5: holding the transmitter in reset returns it to waiting for a sync
  assert_rst_arms_R5: assert property (@(posedge clk) disable iff (!rstN)
    txRst |=> (state == ST_ARM));

  // R5: without a sync an armed transmitter stays armed
  assert_wait_sync_R5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ARM && launch && !fsync && !txRst) |=> (state == ST_ARM));

  // R6: nothing moves without a launch edge
  assert_no_move_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!launch && !txRst) |=> $stable(state) && $stable(remain));

endmodule

// File: rtl/atx_datapath.sv
module atx_datapath
  import atx_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int SH_W  = $clog2(DATA_W) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  txStrobe_t         strobe,
  input  logic [2:0]        wordLenCode,
  input  logic [DATA_W-1:0] wordData,
  input  logic              wordValid,
  output logic              wordReady,
  output logic              wordTaken,
  output logic              sdata,
  output logic              underrun
);

  logic [DATA_W-1:0] holdReg;
  logic              holdFull;
  logic [DATA_W-1:0] lastWord;
  logic [DATA_W-1:0] shReg;
  logic [DATA_W-1:0] pickWord;
  logic [DATA_W-1:0] aligned;
  logic [SH_W-1:0]   shiftAmt;

  assign wordReady = !holdFull;
  assign pickWord  = holdFull ? holdReg : lastWord;
  assign shiftAmt  = SH_W'(DATA_W - wordBits(wordLenCode, DATA_W));
  assign aligned   = pickWord << shiftAmt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdReg   <= '0;
      holdFull  <= 1'b0;
      lastWord  <= '0;
      shReg     <= '0;
      sdata     <= 1'b0;
      underrun  <= 1'b0;
      wordTaken <= 1'b0;
    end else begin
      wordTaken <= 1'b0;
      if (wordValid && !holdFull) begin
        holdReg  <= wordData;
        holdFull <= 1'b1;
      end
      if (strobe.clear) begin
        shReg    <= '0;
        sdata    <= 1'b0;
        underrun <= 1'b0;
      end else if (strobe.loadWord) begin
        lastWord <= pickWord;
        sdata    <= aligned[DATA_W-1];
        shReg    <= aligned << 1;
        if (holdFull) begin
          holdFull  <= 1'b0;
          wordTaken <= 1'b1;
        end else begin
          underrun <= 1'b1;
        end
      end else if (strobe.shiftBit) begin
        sdata <= shReg[DATA_W-1];
        shReg <= shReg << 1;
      end else if (strobe.idleLine) begin
        sdata <= 1'b0;
      end
    end
  end

  // R7: a word is only taken out of a register that was full
  assert_taken_from_full_R7: assert property (@(posedge clk) disable iff (!rstN)
    wordTaken |-> !$past(wordReady));

  // R7: the taken pulse lasts a single cycle
  assert_taken_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    wordTaken |=> !wordTaken);

  // R8: underrun stays set until the transmitter is reset
  assert_underrun_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    (underrun && !strobe.clear) |=> underrun);

endmodule

// File: rtl/audio_word_tx.sv
module audio_word_tx
  import atx_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int FRAME_W = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               txRst,
  input  logic               clkPol,
  input  logic               bclkRise,
  input  logic               bclkFall,
  input  logic               fsync,
  input  logic [2:0]         wordLenCode,
  input  logic [FRAME_W-1:0] frameLen,
  input  logic               dataDelay,
  input  logic               ignoreSync,
  input  logic [DATA_W-1:0]  wordData,
  input  logic               wordValid,
  output logic               wordReady,
  output logic               wordTaken,
  output logic               sdata,
  output logic               underrun
);

  txStrobe_t strobe;
  logic      launch;

  assign launch = clkPol ? bclkFall : bclkRise;

  atx_ctrl #(.DATA_W(DATA_W), .FRAME_W(FRAME_W)) ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .txRst      (txRst),
    .launch     (launch),
    .fsync      (fsync),
    .wordLenCode(wordLenCode),
    .frameLen   (frameLen),
    .dataDelay  (dataDelay),
    .ignoreSync (ignoreSync),
    .strobe     (strobe)
  );

  atx_datapath #(.DATA_W(DATA_W)) dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .wordLenCode(wordLenCode),
    .wordData   (wordData),
    .wordValid  (wordValid),
    .wordReady  (wordReady),
    .wordTaken  (wordTaken),
    .sdata      (sdata),
    .underrun   (underrun)
  );

  // R6: the line only moves after a launch edge or a transmitter reset
  assert_line_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!launch && !txRst) |=> $stable(sdata));

  // R5: the transmitter reset forces the line low
  assert_line_low_R5: assert property (@(posedge clk) disable iff (!rstN)
    txRst |=> !sdata);

endmodule

// File: tb/audio_word_tx_test.sv
`timescale 1ns/1ps
module audio_word_tx_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        txRst = 1'b0;
  logic        clkPol = 1'b1;
  logic        bclkRise = 1'b0;
  logic        bclkFall = 1'b0;
  logic        fsync = 1'b0;
  logic [2:0]  wordLenCode = 3'd2;
  logic [1:0]  frameLen = 2'd1;
  logic        dataDelay = 1'b0;
  logic        ignoreSync = 1'b0;
  logic [31:0] wordData = '0;
  logic        wordValid = 1'b0;
  logic        wordReady;
  logic        wordTaken;
  logic        sdata;
  logic        underrun;

  int checks = 0;
  int errors = 0;
  int takenCnt = 0;

  always #4 clk = ~clk;

  audio_word_tx uut (
    .clk(clk), .rstN(rstN), .txRst(txRst), .clkPol(clkPol),
    .bclkRise(bclkRise), .bclkFall(bclkFall), .fsync(fsync),
    .wordLenCode(wordLenCode), .frameLen(frameLen), .dataDelay(dataDelay),
    .ignoreSync(ignoreSync), .wordData(wordData), .wordValid(wordValid),
    .wordReady(wordReady), .wordTaken(wordTaken), .sdata(sdata),
    .underrun(underrun)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int lenOf(input logic [2:0] code);
    case (code)
      3'd0: return 8;
      3'd1: return 12;
      3'd2: return 16;
      3'd3: return 20;
      3'd4: return 24;
      default: return 32;
    endcase
  endfunction

  // one bit period: launch strobe, then the opposite strobe
  task automatic edgeTx(input logic fs, output logic b);
    @(negedge clk);
    if (clkPol) bclkFall = 1'b1; else bclkRise = 1'b1;
    fsync = fs;
    @(negedge clk);
    bclkRise = 1'b0; bclkFall = 1'b0; fsync = 1'b0;
    b = sdata;
    if (wordTaken) takenCnt++;
    if (clkPol) bclkRise = 1'b1; else bclkFall = 1'b1;
    @(negedge clk);
    bclkRise = 1'b0; bclkFall = 1'b0;
    check("R6 line quiet on opposite edge", 64'(sdata), 64'(b));
  endtask

  task automatic collect(input int n, input logic fsFirst, output logic [63:0] cap);
    cap = '0;
    for (int i = 0; i < n; i++) begin
      logic b;
      edgeTx(fsFirst && (i == 0), b);
      cap = {cap[62:0], b};
    end
  endtask

  task automatic push(input logic [31:0] w);
    @(negedge clk);
    check("R7 ready before write", 64'(wordReady), 64'd1);
    wordData = w; wordValid = 1'b1;
    @(negedge clk);
    wordValid = 1'b0;
    check("R7 ready drops when full", 64'(wordReady), 64'd0);
  endtask

  task automatic cfg(input logic [2:0] code, input logic [1:0] fl, input logic dly,
                     input logic ign, input logic pol);
    @(negedge clk);
    wordLenCode = code; frameLen = fl; dataDelay = dly; ignoreSync = ign; clkPol = pol;
    txRst = 1'b1;
    repeat (2) @(negedge clk);
    txRst = 1'b0;
  endtask

  task automatic testReset();
    check("R9 sdata after reset", 64'(sdata), 64'd0);
    check("R9 ready after reset", 64'(wordReady), 64'd1);
    check("R9 taken after reset", 64'(wordTaken), 64'd0);
    check("R9 underrun after reset", 64'(underrun), 64'd0);
  endtask

  task automatic testStereoNoDelay();
    logic [63:0] c1, c2, c3, c4;
    int t0;
    cfg(3'd2, 2'd1, 1'b0, 1'b0, 1'b1);
    t0 = takenCnt;
    push(32'h1234_A5C3);
    collect(1, 1'b1, c1);
    check("R3 first bit on sync edge", c1[0:0], 64'd1);
    push(32'h0000_3C96);
    collect(15, 1'b0, c2);
    collect(16, 1'b0, c3);
    collect(2, 1'b0, c4);
    check("R1 left word msb first", {48'd0, c1[0], c2[14:0]}, 64'h A5C3);
    check("R2 right word follows", c3, 64'h3C96);
    check("R2 line low after frame", c4, 64'd0);
    check("R7 one pulse per word", 64'(takenCnt - t0), 64'd2);
    check("R8 no underrun when fed", 64'(underrun), 64'd0);
  endtask

  task automatic testDelayBackToBack();
    logic [63:0] c;
    cfg(3'd4, 2'd0, 1'b1, 1'b0, 1'b0);
    push(32'h00C3_5A69);
    collect(1, 1'b1, c);
    check("R3 delay bit is low", c, 64'd0);
    collect(23, 1'b0, c);
    check("R3 delayed word bits", c, 64'(24'hC35A69 >> 1));
    push(32'h0096_F00D);
    collect(1, 1'b1, c);
    check("R3 final bit with expected sync", c, 64'd1);
    collect(24, 1'b0, c);
    check("R3 next frame with no idle bit", c, 64'h96F00D);
    collect(1, 1'b0, c);
    check("R2 idle after mono frame", c, 64'd0);
  endtask

  task automatic testLengths();
    logic [63:0] c;
    logic [31:0] w;
    for (int k = 0; k < 8; k++) begin
      int len;
      len = lenOf(3'(k));
      w = 32'hC3A5_96F1 ^ (32'h1111_1111 * k);
      cfg(3'(k), 2'd0, 1'b0, 1'b0, 1'b1);
      push(w);
      collect(len, 1'b1, c);
      check($sformatf("R1 length code %0d", k), c, 64'(w) & ((64'd1 << len) - 1));
      collect(1, 1'b0, c);
      check($sformatf("R2 idle after code %0d", k), c, 64'd0);
    end
  endtask

  task automatic testIgnoreAndRestart();
    logic [63:0] a, b, c, d;
    cfg(3'd2, 2'd1, 1'b0, 1'b1, 1'b1);
    push(32'h0000_9E37);
    collect(1, 1'b1, a);
    push(32'h0000_61C8);
    collect(7, 1'b0, b);
    collect(1, 1'b1, c);
    collect(7, 1'b0, d);
    check("R4 ignored sync keeps word", {48'd0, a[0], b[6:0], c[0], d[6:0]}, 64'h9E37);
    collect(16, 1'b0, a);
    check("R4 ignored sync keeps slot order", a, 64'h61C8);
    cfg(3'd2, 2'd1, 1'b0, 1'b0, 1'b1);
    push(32'h0000_4D2B);
    collect(1, 1'b1, a);
    push(32'h0000_B7E1);
    collect(7, 1'b0, b);
    collect(1, 1'b1, c);
    push(32'h0000_0F5A);
    collect(15, 1'b0, d);
    check("R4 restart loads new word", {48'd0, c[0], d[14:0]}, 64'hB7E1);
    collect(16, 1'b0, a);
    check("R4 restart then slot 1", a, 64'h0F5A);
    check("R8 no underrun on restart", 64'(underrun), 64'd0);
  endtask

  task automatic testUnderrun();
    logic [63:0] a, b, c;
    int t0;
    cfg(3'd2, 2'd1, 1'b0, 1'b0, 1'b1);
    t0 = takenCnt;
    push(32'h0000_C0DE);
    collect(1, 1'b1, a);
    collect(15, 1'b0, b);
    check("R8 no flag before starve", 64'(underrun), 64'd0);
    collect(16, 1'b0, c);
    check("R8 previous word resent", c, 64'hC0DE);
    check("R8 flag set", 64'(underrun), 64'd1);
    check("R8 no pulse on resend", 64'(takenCnt - t0), 64'd1);
    collect(3, 1'b0, c);
    check("R8 flag sticky", 64'(underrun), 64'd1);
    cfg(3'd2, 2'd1, 1'b0, 1'b0, 1'b1);
    check("R5 reset clears flag", 64'(underrun), 64'd0);
  endtask

  task automatic testTxReset();
    logic [63:0] c;
    cfg(3'd2, 2'd0, 1'b0, 1'b0, 1'b1);
    push(32'h0000_FFFF);
    collect(4, 1'b1, c);
    check("R5 frame running", c, 64'hF);
    @(negedge clk);
    txRst = 1'b1;
    @(negedge clk);
    check("R5 line low in reset", 64'(sdata), 64'd0);
    collect(2, 1'b1, c);
    check("R5 no output while held", c, 64'd0);
    txRst = 1'b0;
    push(32'h0000_A1B2);
    collect(3, 1'b0, c);
    check("R5 waits for sync", c, 64'd0);
    check("R5 held word not taken", 64'(wordReady), 64'd0);
    collect(16, 1'b1, c);
    check("R5 starts on sync", c, 64'hA1B2);
  endtask

  task automatic testPolarity();
    logic [63:0] c;
    cfg(3'd0, 2'd0, 1'b0, 1'b0, 1'b0);
    push(32'h0000_00B4);
    @(negedge clk);
    bclkFall = 1'b1; fsync = 1'b1;
    @(negedge clk);
    bclkFall = 1'b0; fsync = 1'b0;
    @(negedge clk);
    check("R6 sync on non-launch edge ignored", 64'(wordReady), 64'd0);
    check("R6 line unchanged", 64'(sdata), 64'd0);
    collect(2, 1'b0, c);
    check("R6 still waiting", c, 64'd0);
    collect(8, 1'b1, c);
    check("R6 rising launch word", c, 64'hB4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testStereoNoDelay();
    testDelayBackToBack();
    testLengths();
    testIgnoreAndRestart();
    testUnderrun();
    testTxReset();
    testPolarity();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog (all requirements) actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule